// File: doc/BRIEF.md
# DRAM Bank Address Mapper

This block turns a physical byte address into the three coordinates a multi-bank DRAM controller needs: a bank number, a row number and a column (byte offset within the open row). A two-bit mode input, sampled in the same cycle as the address, chooses how the bank number is formed. Three mappings are offered: line-striped, where consecutive cache lines fall into consecutive banks; page-striped, where a whole row-buffer-sized page stays in one bank and consecutive pages rotate through the banks; and scrambled page-striped, where the page-striped bank number is XORed with the lowest bank-width bits of the cache tag.

The scrambled mapping is meant for a memory system behind a set-associative cache. Two addresses that collide in one cache set differ only in their tag bits, so under plain page striping they would land on the same bank and keep closing each other's open row. XORing the tag bits into the bank number sends them to different banks, while every byte of one page still shares a bank. The row and column are taken straight from the address in the page-based modes, so the result stays a one-to-one mapping.

The result is registered: one cycle after an input marked valid, the output carries the coordinates and a valid flag. With the defaults (32-bit address, 16 banks, 2 KB rows, 64-byte lines, a 2 MB two-way cache) the row is bits 31..15, the page-striped bank is bits 14..11, the line-striped bank is bits 9..6 and the lowest tag bits are 23..20.

Top module: `bank_addr_mapper`

## Requirements
- R1: While reset is asserted and until the first valid input is captured, out_valid is 0 and out_bank, out_row and out_col are all 0.
- R2: out_valid equals in_valid of the previous clock cycle, and the result shown is computed from the address and mode captured on that same edge, so the mode may change every cycle.
- R3: In a cycle where in_valid is 0, out_bank, out_row and out_col keep the values they had.
- R4: In every mode out_row equals address bits 31..15.
- R5: Mode code 1 (page-striped): out_bank equals address bits 14..11 and out_col equals address bits 10..0.
- R6: Mode code 0 (line-striped): out_bank equals address bits 9..6 and out_col equals address bits 14..10 placed above address bits 5..0.
- R7: Mode code 2 (scrambled): out_bank equals address bits 14..11 XOR address bits 23..20, and out_col equals address bits 10..0.
- R8: Mode code 3 behaves exactly like mode code 1.
- R9: In mode code 2, sixteen addresses that differ only in bits 23..20 (same cache set, same page-striped bank) yield sixteen different banks.
- R10: In mode code 2, all addresses inside one 2 KB page (only bits 10..0 differ) yield the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Address and mode are presented this cycle |
| in_addr | input | 32 | Physical byte address |
| in_mode | input | 2 | Mapping select: 0 line-striped, 1 page-striped, 2 scrambled, 3 as 1 |
| out_valid | output | 1 | Result below belongs to the input of the previous cycle |
| out_bank | output | 4 | Bank number |
| out_row | output | 17 | Row number |
| out_col | output | 11 | Byte offset within the row |

## Verification
Two events can meet in one cycle: a fresh address with a different mode is captured on the very edge that presents the previous result, so a mode change must not leak into the result still on the outputs. The bench provokes this by issuing back-to-back requests that rotate through all four mode codes every cycle, and a scoreboard compares each result against a value computed in the bench for the mode sent with that address. Idle gaps are mixed in so that holding (R3) is judged in the cycles between bursts.

// File: rtl/amap_pkg.sv
package amap_pkg;

  typedef enum logic [1:0] {
    MAP_LINE  = 2'd0,
    MAP_PAGE  = 2'd1,
    MAP_SCRAM = 2'd2,
    MAP_ALT   = 2'd3
  } map_mode_e;

  function automatic map_mode_e decode_mode(input logic [1:0] code);
    map_mode_e m;
    case (code)
      2'd0:    m = MAP_LINE;
      2'd2:    m = MAP_SCRAM;
      default: m = MAP_PAGE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/amap_rst_sync.sv
module amap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/amap_field_split.sv
module amap_field_split #(
  parameter int ADDR_W = 32,
  parameter int BANK_W = 4,
  parameter int PAGE_W = 11,
  parameter int LINE_W = 6,
  localparam int ROW_W = ADDR_W - PAGE_W - BANK_W,
  localparam int MID_W = PAGE_W - LINE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] page_bank,
  output logic [BANK_W-1:0] line_bank,
  output logic [ROW_W-1:0]  row,
  output logic [PAGE_W-1:0] page_col,
  output logic [PAGE_W-1:0] line_col
);
  assign row       = addr[ADDR_W-1 -: ROW_W];
  assign page_bank = addr[PAGE_W +: BANK_W];
  assign page_col  = addr[PAGE_W-1:0];
  assign line_bank = addr[LINE_W +: BANK_W];

  generate
    if (MID_W > 0) begin : g_mid
      assign line_col = {addr[LINE_W+BANK_W +: MID_W], addr[LINE_W-1:0]};
    end else begin : g_nomid
      assign line_col = addr[LINE_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/amap_bank_scramble.sv
module amap_bank_scramble #(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 4,
  parameter int TAG_LSB = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] conv_bank,
  output logic [BANK_W-1:0] scram_bank
);
  generate
    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
      assign scram_bank[i] = conv_bank[i] ^ addr[TAG_LSB + i];
    end
  endgenerate
endmodule

// File: rtl/amap_out_reg.sv
module amap_out_reg #(
  parameter int BANK_W = 4,
  parameter int ROW_W  = 17,
  parameter int COL_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] bank_d,
  input  logic [ROW_W-1:0]  row_d,
  input  logic [COL_W-1:0]  col_d,
  output logic              valid_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q
);
  logic [BANK_W-1:0] bank_n;
  logic [ROW_W-1:0]  row_n;
  logic [COL_W-1:0]  col_n;

  always_comb begin
    bank_n = bank_q;
    row_n  = row_q;
    col_n  = col_q;
    if (load) begin
      bank_n = bank_d;
      row_n  = row_d;
      col_n  = col_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      valid_q <= load;
      bank_q  <= bank_n;
      row_q   <= row_n;
      col_q   <= col_n;
    end
  end
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper #(
  parameter int ADDR_W      = 32,
  parameter int NUM_BANKS   = 16,
  parameter int ROW_BYTES   = 2048,
  parameter int LINE_BYTES  = 64,
  parameter int CACHE_BYTES = 2097152,
  parameter int CACHE_WAYS  = 2,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int PAGE_W  = $clog2(ROW_BYTES),
  localparam int LINE_W  = $clog2(LINE_BYTES),
  localparam int TAG_LSB = $clog2(CACHE_BYTES / CACHE_WAYS),
  localparam int ROW_W   = ADDR_W - PAGE_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [PAGE_W-1:0] out_col
);
  import amap_pkg::*;

  logic              rst_n_sync;
  logic [BANK_W-1:0] page_bank, line_bank, scram_bank, sel_bank;
  logic [ROW_W-1:0]  row;
  logic [PAGE_W-1:0] page_col, line_col, sel_col;
  map_mode_e         mode;

  amap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  amap_field_split #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .PAGE_W (PAGE_W),
    .LINE_W (LINE_W)
  ) u_split (
    .addr      (in_addr),
    .page_bank (page_bank),
    .line_bank (line_bank),
    .row       (row),
    .page_col  (page_col),
    .line_col  (line_col)
  );

  amap_bank_scramble #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .TAG_LSB (TAG_LSB)
  ) u_scram (
    .addr       (in_addr),
    .conv_bank  (page_bank),
    .scram_bank (scram_bank)
  );

  assign mode = decode_mode(in_mode);

  always_comb begin
    sel_bank = page_bank;
    sel_col  = page_col;
    case (mode)
      MAP_LINE: begin
        sel_bank = line_bank;
        sel_col  = line_col;
      end
      MAP_SCRAM: sel_bank = scram_bank;
      default:   ;
    endcase
  end

  amap_out_reg #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (PAGE_W)
  ) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load    (in_valid),
    .bank_d  (sel_bank),
    .row_d   (row),
    .col_d   (sel_col),
    .valid_q (out_valid),
    .bank_q  (out_bank),
    .row_q   (out_row),
    .col_q   (out_col)
  );
endmodule

// File: rtl/bank_addr_mapper_chk.sv
module bank_addr_mapper_chk #(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 4,
  parameter int PAGE_W  = 11,
  parameter int LINE_W  = 6,
  parameter int TAG_LSB = 20,
  localparam int ROW_W  = ADDR_W - PAGE_W - BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic [BANK_W-1:0] out_bank,
  input logic [ROW_W-1:0]  out_row,
  input logic [PAGE_W-1:0] out_col
);
  // R2: valid follows the input by one cycle
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: outputs hold while idle
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_bank) && $stable(out_row) && $stable(out_col)));

  // R4: row is the top address slice in every mode
  p_row_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_row == $past(in_addr[ADDR_W-1 -: ROW_W]));

  // R5: page-striped column passes through
  p_page_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd1) |=> out_col == $past(in_addr[PAGE_W-1:0]));

  // R6: line-striped bank sits above the line offset
  p_line_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd0) |=> out_bank == $past(in_addr[LINE_W +: BANK_W]));

  // R7: scrambled bank mixes in the low tag bits
  p_scram_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd2) |=>
      out_bank == ($past(in_addr[PAGE_W +: BANK_W]) ^ $past(in_addr[TAG_LSB +: BANK_W])));

  // R8: the spare code acts as page-striped
  p_alt_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd3) |=> out_bank == $past(in_addr[PAGE_W +: BANK_W]));
endmodule

bind bank_addr_mapper bank_addr_mapper_chk #(
  .ADDR_W  (ADDR_W),
  .BANK_W  (BANK_W),
  .PAGE_W  (PAGE_W),
  .LINE_W  (LINE_W),
  .TAG_LSB (TAG_LSB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_bank  (out_bank),
  .out_row   (out_row),
  .out_col   (out_col)
);

// File: tb/tb_bank_addr_mapper.sv
module tb_bank_addr_mapper;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_addr;
  logic [1:0]  in_mode;
  logic        out_valid;
  logic [3:0]  out_bank;
  logic [16:0] out_row;
  logic [10:0] out_col;

  typedef struct {
    logic [3:0]  bank;
    logic [16:0] row;
    logic [10:0] col;
    string       tag;
  } exp_t;

  exp_t       sb[$];
  logic [3:0] obs_bank[$];
  int         checks = 0;
  int         errors = 0;
  logic       have_last = 1'b0;
  exp_t       last;
  logic       running = 1'b0;

  bank_addr_mapper dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_bank  (out_bank),
    .out_row   (out_row),
    .out_col   (out_col)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic exp_t model(input logic [31:0] a, input logic [1:0] m, input string tag);
    exp_t e;
    e.row = a[31:15];
    e.tag = tag;
    case (m)
      2'd0: begin
        e.bank = a[9:6];
        e.col  = {a[14:10], a[5:0]};
      end
      2'd2: begin
        e.bank = a[14:11] ^ a[23:20];
        e.col  = a[10:0];
      end
      default: begin
        e.bank = a[14:11];
        e.col  = a[10:0];
      end
    endcase
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] m, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    in_mode  = m;
    sb.push_back(model(a, m, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_addr  = 32'hDEAD_BEEF;
      in_mode  = 2'd2;
    end
  endtask

  // monitor: samples just after each rising edge
  always @(posedge clk) begin
    #1;
    if (running) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected valid", "no pending item");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_bank == e.bank, e.tag, $sformatf("bank=%0h", out_bank), $sformatf("bank=%0h", e.bank));
          check(out_row == e.row, "R4", $sformatf("row=%0h", out_row), $sformatf("row=%0h", e.row));
          check(out_col == e.col, e.tag, $sformatf("col=%0h", out_col), $sformatf("col=%0h", e.col));
          obs_bank.push_back(out_bank);
          last = e;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check(out_bank == last.bank && out_row == last.row && out_col == last.col, "R3",
              $sformatf("%0h/%0h/%0h", out_bank, out_row, out_col),
              $sformatf("%0h/%0h/%0h", last.bank, last.row, last.col));
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_addr  = '0;
    in_mode  = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_bank == 0 && out_row == 0 && out_col == 0, "R1",
          $sformatf("v=%0b %0h/%0h/%0h", out_valid, out_bank, out_row, out_col), "v=0 0/0/0");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && out_bank == 0 && out_row == 0 && out_col == 0, "R1",
          $sformatf("v=%0b %0h/%0h/%0h", out_valid, out_bank, out_row, out_col), "v=0 0/0/0");
    running = 1'b1;

    // R5 page-striped, R6 line-striped, R7 scrambled, R8 spare code
    send(32'h1234_5678, 2'd1, "R5");
    send(32'h1234_5678, 2'd0, "R6");
    send(32'h1234_5678, 2'd2, "R7");
    send(32'h1234_5678, 2'd3, "R8");
    idle(3);
    send(32'hFFFF_FFFF, 2'd0, "R6");
    send(32'h0000_0000, 2'd2, "R7");
    send(32'hA5A5_5A5A, 2'd3, "R8");
    send(32'h00F0_7800, 2'd2, "R7");
    idle(2);
    // R2: mode rotates every cycle with back-to-back addresses
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = 32'h9E37_79B9 * (i + 1) + 32'h0101_0101 * i;
      send(a, 2'(i % 4), "R2");
    end
    idle(4);
    // R9: same set, differing low tag bits
    obs_bank.delete();
    for (int i = 0; i < 16; i++) send(32'h4000_3A40 | (32'(i) << 20), 2'd2, "R9");
    idle(3);
    begin
      logic [15:0] seen;
      seen = '0;
      foreach (obs_bank[j]) seen[obs_bank[j]] = 1'b1;
      check(obs_bank.size() == 16 && seen == 16'hFFFF, "R9",
            $sformatf("map=%0h n=%0d", seen, obs_bank.size()), "map=ffff n=16");
    end
    // R10: one page, all offsets patterns
    obs_bank.delete();
    for (int i = 0; i < 12; i++) send(32'h0357_6800 | ((32'(i) * 32'd173) & 32'h7FF), 2'd2, "R10");
    idle(3);
    begin
      bit same;
      same = (obs_bank.size() == 12);
      foreach (obs_bank[j]) if (obs_bank[j] != obs_bank[0]) same = 1'b0;
      check(same, "R10", $sformatf("n=%0d first=%0h", obs_bank.size(), obs_bank[0]), "n=12 all equal");
    end
    idle(2);
    check(sb.size() == 0, "R2", $sformatf("pending=%0d", sb.size()), "pending=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule